// File: doc/BRIEF.md
# I2C ADC Channel Read Sequencer

This block drives a byte-level I2C master controller so that a single user request yields one conversion result from an I2C analog-to-digital converter. The user raises `req` for a cycle with a channel number. The sequencer then runs two bus transactions with a stop between them. The first transaction selects the channel. The second transaction reads back a burst of samples, of which only the last one is kept.

The sequencer talks to the master one command at a time. It issues start, write-byte, read-byte (with the acknowledge bit to send) or stop, then waits for the master's completion pulse. On completion it checks the master's status code against the code expected for that step. A mismatch at any step aborts the sequence. The block then sends a stop, drops the bus enable and pulses `err`. A clean run ends with a one-cycle `done` and the final sample on `result`.

The converter's 7-bit bus address and the number of discarded samples are parameters. With the defaults, the address byte is 0x90 for writing and 0x91 for reading, and four samples are thrown away.

Top module: `i2c_adc_read_seq`

## Requirements
- R1: After reset, `done`, `err`, `bus_en`, `cmd_req` and `result` are all zero.
- R2: A request first issues, in this order: START, WRITE 0x90, WRITE of the channel byte (channel in bits 1:0, bits 7:2 zero), STOP. The command codes on `cmd_op` are START=0, WRITE=1, READ=2, STOP=3.
- R3: The sequencer then issues START, WRITE 0x91, four READs with `cmd_ack`=1, one READ with `cmd_ack`=0, and a final STOP.
- R4: `done` pulses in the cycle after the master completes the final STOP. `result` then holds the data returned by the READ issued with `cmd_ack`=0, and keeps that value until the next clean finish.
- R5: The expected status codes are: 0x08 or 0x10 after START; 0x18 after WRITE 0x90; 0x28 after the channel byte; 0x40 after WRITE 0x91; 0x50 after an acknowledged READ; 0x58 after the last READ. The status of a STOP is not checked. Any other code makes the next command a STOP. `err` pulses in the cycle after that STOP completes, and no further command follows.
- R6: `bus_en` rises together with the first START command. It stays high until the cycle in which `done` or `err` pulses, and is low in that cycle.
- R7: A request that arrives while a sequence is in progress is ignored. The command stream is unchanged and no second sequence follows.
- R8: `done` and `err` last one cycle each and are never high together.
- R9: `cmd_req` is a one-cycle pulse. It is issued only when no earlier command is still awaiting `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start-of-sequence request pulse |
| chan | input | CHAN_W | Converter channel to read |
| done | output | 1 | Sequence finished cleanly (pulse) |
| err | output | 1 | Sequence aborted (pulse) |
| result | output | 8 | Captured final sample |
| bus_en | output | 1 | Enable to the I2C master |
| cmd_req | output | 1 | Command strobe to the master |
| cmd_op | output | 2 | Command code: 0 start, 1 write, 2 read, 3 stop |
| cmd_data | output | 8 | Byte to write |
| cmd_ack | output | 1 | Acknowledge bit to send after a read |
| cmd_done | input | 1 | Master completion pulse |
| cmd_status | input | 8 | Master status code, valid with `cmd_done` |
| cmd_rdata | input | 8 | Received byte, valid with `cmd_done` |

## Verification
Clean runs cover all four channel values. Each run returns a different sample ramp, so a wrong channel byte or a capture of the wrong read index shows up directly. The master's response latency is varied between runs, which separates a design that waits for completion from one that assumes fixed timing. One run answers the second START with the repeated-start code, to check that both start codes are accepted. Faulty status codes are injected at the first START, each of the three writes, an acknowledged read and the final read. Each of these runs must truncate the command stream to exactly one STOP and end in `err`. A stray request in the middle of a run must leave the stream and the outcome untouched.

// File: rtl/i2c_adc_seq_pkg.sv
package i2c_adc_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    EXP_NONE,
    EXP_START,
    EXP_ADDR_W,
    EXP_DATA_W,
    EXP_ADDR_R,
    EXP_RD_ACK,
    EXP_RD_NACK
  } expect_e;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RESTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_DW_ACK  = 8'h28;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_RD_ACK  = 8'h50;
  localparam logic [7:0] ST_RD_NACK = 8'h58;

  typedef struct packed {
    bus_op_e    op;
    logic [7:0] data;
    logic       ack;
    expect_e    expect_st;
  } step_cmd_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_ABORT
  } seq_state_e;

endpackage

// File: rtl/adc_seq_steps.sv
module adc_seq_steps
  import i2c_adc_seq_pkg::*;
#(
  parameter logic [6:0] ADDR7   = 7'h48,
  parameter int         CHAN_W  = 2,
  parameter int         DISCARD = 4,
  parameter int         STEP_W  = 4
) (
  input  logic [STEP_W-1:0] step,
  input  logic [CHAN_W-1:0] chan,
  output step_cmd_t         cmd
);
  localparam int RD_FIRST = 6;
  localparam int RD_LAST  = RD_FIRST + DISCARD;

  always_comb begin
    cmd.op        = OP_STOP;
    cmd.data      = 8'h00;
    cmd.ack       = 1'b0;
    cmd.expect_st = EXP_NONE;
    if (int'(step) == 0 || int'(step) == 4) begin
      cmd.op        = OP_START;
      cmd.expect_st = EXP_START;
    end else if (int'(step) == 1) begin
      cmd.op        = OP_WRITE;
      cmd.data      = {ADDR7, 1'b0};
      cmd.expect_st = EXP_ADDR_W;
    end else if (int'(step) == 2) begin
      cmd.op        = OP_WRITE;
      cmd.data      = 8'(chan);
      cmd.expect_st = EXP_DATA_W;
    end else if (int'(step) == 5) begin
      cmd.op        = OP_WRITE;
      cmd.data      = {ADDR7, 1'b1};
      cmd.expect_st = EXP_ADDR_R;
    end else if (int'(step) >= RD_FIRST && int'(step) < RD_LAST) begin
      cmd.op        = OP_READ;
      cmd.ack       = 1'b1;
      cmd.expect_st = EXP_RD_ACK;
    end else if (int'(step) == RD_LAST) begin
      cmd.op        = OP_READ;
      cmd.expect_st = EXP_RD_NACK;
    end
  end
endmodule

// File: rtl/adc_seq_status_check.sv
module adc_seq_status_check
  import i2c_adc_seq_pkg::*;
(
  input  expect_e    exp_st,
  input  logic [7:0] status,
  output logic       ok
);
  always_comb begin
    case (exp_st)
      EXP_START:   ok = (status == ST_START) || (status == ST_RESTART);
      EXP_ADDR_W:  ok = (status == ST_AW_ACK);
      EXP_DATA_W:  ok = (status == ST_DW_ACK);
      EXP_ADDR_R:  ok = (status == ST_AR_ACK);
      EXP_RD_ACK:  ok = (status == ST_RD_ACK);
      EXP_RD_NACK: ok = (status == ST_RD_NACK);
      default:     ok = 1'b1;
    endcase
  end
endmodule

// File: rtl/i2c_adc_read_seq.sv
module i2c_adc_read_seq
  import i2c_adc_seq_pkg::*;
#(
  parameter logic [6:0] ADDR7   = 7'h48,
  parameter int         CHAN_W  = 2,
  parameter int         DISCARD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [CHAN_W-1:0] chan,
  output logic              done,
  output logic              err,
  output logic [7:0]        result,
  output logic              bus_en,
  output logic              cmd_req,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_data,
  output logic              cmd_ack,
  input  logic              cmd_done,
  input  logic [7:0]        cmd_status,
  input  logic [7:0]        cmd_rdata
);
  localparam int FINAL_STEP = 7 + DISCARD;
  localparam int STEP_W     = $clog2(FINAL_STEP + 2);

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic [CHAN_W-1:0] chan_q;
  expect_e           exp_q;

  logic [STEP_W-1:0] step_sel;
  logic [CHAN_W-1:0] chan_sel;
  step_cmd_t         nxt;
  logic              status_ok;

  assign step_sel = (state == S_IDLE) ? '0 : step + 1'b1;
  assign chan_sel = (state == S_IDLE) ? chan : chan_q;

  adc_seq_steps #(
    .ADDR7(ADDR7), .CHAN_W(CHAN_W), .DISCARD(DISCARD), .STEP_W(STEP_W)
  ) u_steps (
    .step(step_sel), .chan(chan_sel), .cmd(nxt)
  );

  adc_seq_status_check u_check (
    .exp_st(exp_q), .status(cmd_status), .ok(status_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      step     <= '0;
      chan_q   <= '0;
      exp_q    <= EXP_NONE;
      done     <= 1'b0;
      err      <= 1'b0;
      result   <= 8'h00;
      bus_en   <= 1'b0;
      cmd_req  <= 1'b0;
      cmd_op   <= 2'd0;
      cmd_data <= 8'h00;
      cmd_ack  <= 1'b0;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      cmd_req <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req) begin
            chan_q   <= chan;
            step     <= '0;
            bus_en   <= 1'b1;
            cmd_req  <= 1'b1;
            cmd_op   <= nxt.op;
            cmd_data <= nxt.data;
            cmd_ack  <= nxt.ack;
            exp_q    <= nxt.expect_st;
            state    <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (cmd_done) begin
            if (int'(step) == FINAL_STEP) begin
              done   <= 1'b1;
              bus_en <= 1'b0;
              state  <= S_IDLE;
            end else if (!status_ok) begin
              cmd_req  <= 1'b1;
              cmd_op   <= OP_STOP;
              cmd_data <= 8'h00;
              cmd_ack  <= 1'b0;
              state    <= S_ABORT;
            end else begin
              if (exp_q == EXP_RD_NACK) result <= cmd_rdata;
              step     <= step + 1'b1;
              cmd_req  <= 1'b1;
              cmd_op   <= nxt.op;
              cmd_data <= nxt.data;
              cmd_ack  <= nxt.ack;
              exp_q    <= nxt.expect_st;
            end
          end
        end
        S_ABORT: begin
          if (cmd_done) begin
            err    <= 1'b1;
            bus_en <= 1'b0;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_props.sv
module adc_seq_props (
  input logic clk,
  input logic rst,
  input logic done,
  input logic err,
  input logic bus_en,
  input logic cmd_req,
  input logic cmd_done
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= 1'b0;
    else if (cmd_req) outstanding <= 1'b1;
    else if (cmd_done) outstanding <= 1'b0;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst) err |=> !err);
  assert_excl_R8: assert property (@(posedge clk) disable iff (rst) !(done && err));
  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (rst) cmd_req |=> !cmd_req);
  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (rst) cmd_req |-> !outstanding);
  assert_en_with_cmd_R6: assert property (@(posedge clk) disable iff (rst) cmd_req |-> bus_en);
  assert_en_off_at_end_R6: assert property (@(posedge clk) disable iff (rst) (done || err) |-> !bus_en);
  assert_quiet_after_err_R5: assert property (@(posedge clk) disable iff (rst) err |-> !cmd_req);
endmodule

bind i2c_adc_read_seq adc_seq_props u_props (
  .clk(clk), .rst(rst), .done(done), .err(err), .bus_en(bus_en),
  .cmd_req(cmd_req), .cmd_done(cmd_done)
);

// File: tb/test_i2c_adc_read_seq.sv
module test_i2c_adc_read_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst, req;
  logic [1:0] chan;
  logic       done, err, bus_en, cmd_req, cmd_ack;
  logic [7:0] result, cmd_data;
  logic [1:0] cmd_op;
  logic       cmd_done;
  logic [7:0] cmd_status, cmd_rdata;

  i2c_adc_read_seq i_i2c_adc_read_seq (
    .clk(clk), .rst(rst), .req(req), .chan(chan), .done(done), .err(err),
    .result(result), .bus_en(bus_en), .cmd_req(cmd_req), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_ack(cmd_ack), .cmd_done(cmd_done),
    .cmd_status(cmd_status), .cmd_rdata(cmd_rdata)
  );

  int total = 0, bad = 0;
  int expq[$];
  int stsq[$];
  int rdq[$];
  int cmd_idx, lat, busy_cnt, pend, cur;
  bit exp_en, seen_done, seen_err, abort_run;
  logic [7:0] exp_result = 8'h00;

  task automatic chk(input bit c, input string rq, input string what, input int act, input int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int enc(input int op, input int ack, input int data);
    return op * 512 + ack * 256 + data;
  endfunction

  // behavioural master model and per-clock reference comparison
  initial begin
    cmd_done = 0; cmd_status = 0; cmd_rdata = 0;
    cmd_idx = 0; busy_cnt = 0; pend = 0; exp_en = 0;
    forever begin
      @(negedge clk);
      cmd_done = 0;
      if (!rst) begin
        if (pend != 0) exp_en = 0;
        if (cmd_req) begin
          if (cmd_idx < expq.size()) begin
            string rq;
            if (abort_run && cmd_idx == expq.size() - 1) rq = "R5";
            else if (cmd_idx < 4) rq = "R2";
            else rq = "R3";
            chk(enc(int'(cmd_op), int'(cmd_ack), int'(cmd_data)) == expq[cmd_idx], rq,
                "command word", enc(int'(cmd_op), int'(cmd_ack), int'(cmd_data)), expq[cmd_idx]);
            if (cmd_idx == 0) exp_en = 1;
          end else begin
            chk(0, "R7", "unexpected command", cmd_idx, expq.size());
          end
          cur = cmd_idx;
          cmd_idx++;
          busy_cnt = lat;
        end
        chk(done == (pend == 1), "R4", "done", int'(done), int'(pend == 1));
        chk(err == (pend == 2), "R5", "err", int'(err), int'(pend == 2));
        chk(bus_en == exp_en, "R6", "bus_en", int'(bus_en), int'(exp_en));
        if (pend == 1) chk(result == exp_result, "R4", "result", int'(result), int'(exp_result));
        if (done) seen_done = 1;
        if (err) seen_err = 1;
        pend = 0;
        if (!cmd_req && busy_cnt > 0) begin
          busy_cnt--;
          if (busy_cnt == 0) begin
            cmd_done = 1;
            cmd_status = (cur < stsq.size()) ? 8'(stsq[cur]) : 8'h00;
            cmd_rdata = (cur < rdq.size()) ? 8'(rdq[cur]) : 8'h00;
            if (cur == expq.size() - 1) pend = abort_run ? 2 : 1;
          end
        end
      end
    end
  end

  task automatic run(input int ch, input int l, input int rbase, input int inj,
                     input int inj_val, input bit restart, input bit poke);
    expq = {enc(0,0,0), enc(1,0,8'h90), enc(1,0,ch), enc(3,0,0),
            enc(0,0,0), enc(1,0,8'h91), enc(2,1,0), enc(2,1,0),
            enc(2,1,0), enc(2,1,0), enc(2,0,0), enc(3,0,0)};
    stsq = {8'h08, 8'h18, 8'h28, 8'h00, restart ? 8'h10 : 8'h08, 8'h40,
            8'h50, 8'h50, 8'h50, 8'h50, 8'h58, 8'h00};
    rdq = {0, 0, 0, 0, 0, 0, rbase, rbase + 1, rbase + 2, rbase + 3, rbase + 4, 0};
    abort_run = (inj >= 0);
    if (abort_run) begin
      stsq[inj] = inj_val;
      while (expq.size() > inj + 1) void'(expq.pop_back());
      expq.push_back(enc(3,0,0));
    end else begin
      exp_result = 8'(rbase + 4);
    end
    lat = l; cmd_idx = 0; seen_done = 0; seen_err = 0;
    @(negedge clk);
    req = 1; chan = 2'(ch);
    @(negedge clk);
    req = 0; chan = 0;
    if (poke) begin
      repeat (15) @(negedge clk);
      req = 1; chan = 2'(ch ^ 3);
      @(negedge clk);
      req = 0;
    end
    for (int i = 0; i < 3000 && !(seen_done || seen_err); i++) @(negedge clk);
    chk(seen_done == !abort_run, abort_run ? "R5" : "R4", "finished cleanly", int'(seen_done), int'(!abort_run));
    chk(seen_err == abort_run, "R5", "aborted", int'(seen_err), int'(abort_run));
    repeat (40) @(negedge clk);
    chk(cmd_idx == expq.size(), poke ? "R7" : "R5", "command count", cmd_idx, expq.size());
  endtask

  initial begin
    rst = 1; req = 0; chan = 0; lat = 1; abort_run = 0;
    repeat (4) @(negedge clk);
    chk(!done && !err && !bus_en && !cmd_req && result == 0, "R1", "reset outputs",
        int'({done, err, bus_en, cmd_req}), 0);
    rst = 0;
    run(0, 1, 8'h10, -1, 0, 0, 0);
    run(1, 3, 8'h40, -1, 0, 1, 0);
    run(2, 2, 8'h80, -1, 0, 0, 0);
    run(3, 5, 8'hC3, -1, 0, 0, 0);
    run(1, 2, 8'h20, 0, 8'h38, 0, 0);
    run(2, 1, 8'h20, 1, 8'h20, 0, 0);
    run(3, 2, 8'h20, 2, 8'h30, 0, 0);
    run(0, 1, 8'h20, 5, 8'h48, 0, 0);
    run(1, 3, 8'h20, 7, 8'h58, 0, 0);
    run(2, 1, 8'h20, 10, 8'h50, 0, 0);
    run(2, 4, 8'h66, -1, 0, 0, 1);
    chk(result == 8'h6A, "R4", "result held after run", int'(result), 8'h6A);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired R4 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule